// File: doc/BRIEF.md
# Mains-Synchronised Duty-Cycle Table Sequencer

The block drives a boost power-factor stage from duty cycles that were computed ahead of time for one rectified mains half-cycle. Three component tables are held on chip: the complement of the average-voltage part, the complement of the first duty part, and a current-shaping correction. On every switching-period tick the block reads one entry from each table and applies the regulator gains. The average-voltage gain k scales both complement tables. The correction is scaled by an approximate reciprocal of k, formed as two minus k. A ripple-loop gain scales the load-dependent sum. The result is one saturated duty word for the PWM.

Playback restarts when a debounced mains zero-crossing comparator rises. The block counts how many ticks the previous half-cycle lasted. It then maps ticks onto table entries so that, when the half-cycle is longer than the table, the repeated entries are spread evenly across it, and when it is shorter, the skipped entries are spread evenly. Gain formats are unsigned with 14 fractional bits, so unity is 16384. Table entries and the duty word count PWM steps with 5 fractional bits, so full duty is PWM_STEPS·32.

Top module: `pfc_duty_seq`

## Requirements
- R1: While reset is asserted, and after reset until the first accepted zero crossing, `duty` is 0, including when ticks arrive.
- R2: A cycle with `tbl_we` high writes `tbl_data` to entry `tbl_addr` of the table chosen by `tbl_sel`. The encodings are 0 for the average-part complement (A), 1 for the first-part complement (B) and 2 for the signed correction (C).
- R3: A change of `cmp_raw`, after a two-flop synchroniser, is accepted only after it has persisted for DEB_CYCLES consecutive clocks. A pulse shorter than that leaves playback untouched.
- R4: The rising edge of the accepted comparator level restarts playback, and the first tick afterwards plays entry 0.
- R5: `duty` changes only on the clock edge that samples `sw_tick` high. It holds its value in every other cycle.
- R6: With F = PWM_STEPS·32, the average part is a = F − ((k·A)>>>14) and the first part is p = F − ((k·B)>>>14), where `>>>` is an arithmetic shift (floor).
- R7: The correction is c = ((32768 − k)·C)>>>14. The output before limiting is a + (((p − a) + c)·g>>>14), with g = `gain_rip`.
- R8: For tick j (counted from 0) of a half-cycle, the entry played is min(floor(j·N/M), N−1). M is the tick count of the previous half-cycle, raised to at least N/2, and M is N after the first crossing.
- R9: `duty` saturates to the range 0 to F−1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Raw zero-crossing comparator output |
| sw_tick | input | 1 | One-clock pulse per switching period |
| gain_k | input | 16 | Average-voltage gain k, unsigned, 14 fractional bits |
| gain_rip | input | 16 | Ripple-loop gain, unsigned, 14 fractional bits |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Table select (0 A, 1 B, 2 C) |
| tbl_addr | input | IDX_W | Table entry address |
| tbl_data | input | 16 | Entry value, two's complement, 5 fractional bits |
| duty | output | 16 | Duty command, 5 fractional bits |

## Verification
Playback is exercised with a nominal half-cycle, with one lengthened to 24 ticks, with ones shortened to 10 ticks, and with a very short one that forces the lower clamp on M. These cases separate even repetition, even skipping, the final-entry clamp and the minimum-length clamp. The gains are stepped from unity to off-unity values of k and of the ripple gain, which separates the error terms produced by k, by the approximate reciprocal and by the ripple loop. A comparator glitch in the middle of a half-cycle shows whether the debounce can restart playback when it should not. A large k, together with entries whose complement is zero, drives the output into both saturation limits.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;
    localparam int ENTRY_W   = 16;
    localparam int GAIN_W    = 16;
    localparam int GAIN_FRAC = 14;
    localparam int MATH_W    = 40;

    typedef enum logic [1:0] {
        TBL_AVG_CMP  = 2'd0,
        TBL_PRI_CMP  = 2'd1,
        TBL_CORR     = 2'd2
    } tbl_sel_e;
endpackage

// File: rtl/pfc_zc_filter.sv
module pfc_zc_filter #(
    parameter int DEB_CYCLES = 1024,
    localparam int CW = $clog2(DEB_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_raw,
    output logic zc_event
);
    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          lvl;
        logic          lvl_prev;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t q, n;

    always_comb begin
        n          = q;
        n.s1       = cmp_raw;
        n.s2       = q.s1;
        n.lvl_prev = q.lvl;
        if (q.s2 != q.lvl) begin
            if (q.cnt == CW'(DEB_CYCLES - 1)) begin
                n.lvl = q.s2;
                n.cnt = '0;
            end else begin
                n.cnt = q.cnt + 1'b1;
            end
        end else begin
            n.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign zc_event = q.lvl & ~q.lvl_prev;

    AST_LEVEL_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.lvl) |-> $past(q.s2)); // R3
    AST_RUN_BEFORE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.lvl) |-> $past(q.cnt) == CW'(DEB_CYCLES - 1)); // R3
endmodule

// File: rtl/pfc_table_store.sv
module pfc_table_store #(
    parameter int N_ENTRIES = 1000,
    parameter int IDX_W     = 10,
    parameter int EW        = 16
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [EW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [EW-1:0]    rd_avg_cmp,
    output logic [EW-1:0]    rd_pri_cmp,
    output logic [EW-1:0]    rd_corr
);
    logic [EW-1:0] rd_word [3];
    logic          addr_ok;

    assign addr_ok = {1'b0, wr_addr} < (IDX_W + 1)'(N_ENTRIES);

    for (genvar g = 0; g < 3; g++) begin : g_tbl
        logic [EW-1:0] mem [N_ENTRIES];
        always_ff @(posedge clk) begin
            if (wr_en && addr_ok && wr_sel == 2'(g)) mem[wr_addr] <= wr_data;
        end
        assign rd_word[g] = mem[rd_addr];
    end

    assign rd_avg_cmp = rd_word[0];
    assign rd_pri_cmp = rd_word[1];
    assign rd_corr    = rd_word[2];
endmodule

// File: rtl/pfc_phase_index.sv
module pfc_phase_index #(
    parameter int N_ENTRIES = 1000,
    parameter int IDX_W     = 10,
    localparam int CNT_W    = IDX_W + 2,
    localparam int ACC_W    = CNT_W + 2,
    localparam int MIN_LEN  = (N_ENTRIES / 2 > 0) ? N_ENTRIES / 2 : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             zc_event,
    output logic [IDX_W-1:0] idx,
    output logic             synced,
    output logic             fire
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] span;
        logic             synced;
    } ph_t;

    ph_t q, n;

    logic [ACC_W-1:0] acc_sum;
    logic [ACC_W-1:0] span_x;
    logic [IDX_W+1:0] idx_w;
    logic [1:0]       adv;
    logic [CNT_W-1:0] span_new;

    assign fire = tick & q.synced & ~zc_event;

    always_comb begin
        n        = q;
        span_x   = ACC_W'(q.span);
        acc_sum  = q.acc + ACC_W'(N_ENTRIES);
        adv      = 2'd0;
        span_new = (q.run < CNT_W'(MIN_LEN)) ? CNT_W'(MIN_LEN) : q.run;
        if (acc_sum >= (span_x << 1)) begin
            adv     = 2'd2;
            acc_sum = acc_sum - (span_x << 1);
        end else if (acc_sum >= span_x) begin
            adv     = 2'd1;
            acc_sum = acc_sum - span_x;
        end
        idx_w = {2'b00, q.idx} + {{IDX_W{1'b0}}, adv};

        if (zc_event) begin
            n.synced = 1'b1;
            n.idx    = '0;
            n.acc    = '0;
            n.run    = '0;
            n.span   = q.synced ? span_new : CNT_W'(N_ENTRIES);
        end else if (fire) begin
            n.run = (q.run == {CNT_W{1'b1}}) ? q.run : q.run + 1'b1;
            n.acc = acc_sum;
            n.idx = (idx_w > (IDX_W + 2)'(N_ENTRIES - 1)) ? IDX_W'(N_ENTRIES - 1)
                                                           : idx_w[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign idx    = q.idx;
    assign synced = q.synced;

    AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        zc_event |=> (idx == '0) && synced); // R4
    AST_INDEX_NO_BACKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> idx >= $past(idx)); // R8
    AST_INDEX_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (idx - $past(idx)) <= IDX_W'(2)); // R8
    AST_INDEX_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, idx} < (IDX_W + 1)'(N_ENTRIES)); // R8
endmodule

// File: rtl/pfc_duty_mix.sv
module pfc_duty_mix
    import pfc_seq_pkg::*;
#(
    parameter int PWM_STEPS = 1000,
    parameter int FRAC_W    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic               synced,
    input  logic [ENTRY_W-1:0] ent_avg_cmp,
    input  logic [ENTRY_W-1:0] ent_pri_cmp,
    input  logic [ENTRY_W-1:0] ent_corr,
    input  logic [GAIN_W-1:0]  gain_k,
    input  logic [GAIN_W-1:0]  gain_rip,
    output logic [ENTRY_W-1:0] duty
);
    localparam logic signed [MATH_W-1:0] UNITY = MATH_W'(1) <<< GAIN_FRAC;
    localparam logic signed [MATH_W-1:0] FULL  = MATH_W'(PWM_STEPS) <<< FRAC_W;
    localparam logic signed [MATH_W-1:0] CEIL  = FULL - MATH_W'(1);

    typedef struct packed {
        logic [ENTRY_W-1:0] duty;
    } mix_t;

    mix_t q, n;

    logic signed [MATH_W-1:0] k_s, kinv_s, g_s, a_s, b_s, c_s;
    logic signed [MATH_W-1:0] avg_part, pri_part, corr_part, load_sum, load_part, total;
    logic [ENTRY_W-1:0]       limited;

    always_comb begin
        k_s    = $signed({{(MATH_W - GAIN_W){1'b0}}, gain_k});
        g_s    = $signed({{(MATH_W - GAIN_W){1'b0}}, gain_rip});
        a_s    = $signed({{(MATH_W - ENTRY_W){ent_avg_cmp[ENTRY_W-1]}}, ent_avg_cmp});
        b_s    = $signed({{(MATH_W - ENTRY_W){ent_pri_cmp[ENTRY_W-1]}}, ent_pri_cmp});
        c_s    = $signed({{(MATH_W - ENTRY_W){ent_corr[ENTRY_W-1]}}, ent_corr});
        kinv_s = (UNITY <<< 1) - k_s;

        avg_part  = FULL - ((k_s * a_s) >>> GAIN_FRAC);
        pri_part  = FULL - ((k_s * b_s) >>> GAIN_FRAC);
        corr_part = (kinv_s * c_s) >>> GAIN_FRAC;
        load_sum  = (pri_part - avg_part) + corr_part;
        load_part = (load_sum * g_s) >>> GAIN_FRAC;
        total     = avg_part + load_part;

        if (total < 0)         limited = '0;
        else if (total > CEIL) limited = CEIL[ENTRY_W-1:0];
        else                   limited = total[ENTRY_W-1:0];

        n = q;
        if (fire) n.duty = limited;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign duty = q.duty;

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(duty)); // R5
    AST_ZERO_BEFORE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |-> duty == '0); // R1
endmodule

// File: rtl/pfc_duty_seq.sv
module pfc_duty_seq
    import pfc_seq_pkg::*;
#(
    parameter int N_ENTRIES  = 1000,
    parameter int DEB_CYCLES = 1024,
    parameter int PWM_STEPS  = 1000,
    parameter int FRAC_W     = 5,
    localparam int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmp_raw,
    input  logic               sw_tick,
    input  logic [GAIN_W-1:0]  gain_k,
    input  logic [GAIN_W-1:0]  gain_rip,
    input  logic               tbl_we,
    input  logic [1:0]         tbl_sel,
    input  logic [IDX_W-1:0]   tbl_addr,
    input  logic [ENTRY_W-1:0] tbl_data,
    output logic [ENTRY_W-1:0] duty
);
    localparam int DUTY_CEIL = PWM_STEPS * (1 << FRAC_W) - 1;

    logic               zc_event;
    logic [IDX_W-1:0]   play_idx;
    logic               synced;
    logic               fire;
    logic [ENTRY_W-1:0] ent_avg_cmp, ent_pri_cmp, ent_corr;

    pfc_zc_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_raw  (cmp_raw),
        .zc_event (zc_event)
    );

    pfc_phase_index #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sw_tick),
        .zc_event (zc_event),
        .idx      (play_idx),
        .synced   (synced),
        .fire     (fire)
    );

    pfc_table_store #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W), .EW(ENTRY_W)) u_store (
        .clk        (clk),
        .wr_en      (tbl_we),
        .wr_sel     (tbl_sel),
        .wr_addr    (tbl_addr),
        .wr_data    (tbl_data),
        .rd_addr    (play_idx),
        .rd_avg_cmp (ent_avg_cmp),
        .rd_pri_cmp (ent_pri_cmp),
        .rd_corr    (ent_corr)
    );

    pfc_duty_mix #(.PWM_STEPS(PWM_STEPS), .FRAC_W(FRAC_W)) u_mix (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .synced      (synced),
        .ent_avg_cmp (ent_avg_cmp),
        .ent_pri_cmp (ent_pri_cmp),
        .ent_corr    (ent_corr),
        .gain_k      (gain_k),
        .gain_rip    (gain_rip),
        .duty        (duty)
    );

    AST_DUTY_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        duty <= ENTRY_W'(DUTY_CEIL)); // R9
    AST_NO_PLAY_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_tick && !synced) |=> duty == '0); // R1
endmodule

// File: tb/sim_pfc_duty_seq.sv
module sim_pfc_duty_seq;
    localparam int N    = 16;
    localparam int DEB  = 8;
    localparam int FULL = 32000;
    localparam int RMAX = 63;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_raw = 1'b0;
    logic        sw_tick = 1'b0;
    logic [15:0] gain_k = 16'd16384;
    logic [15:0] gain_rip = 16'd16384;
    logic        tbl_we = 1'b0;
    logic [1:0]  tbl_sel = 2'd0;
    logic [3:0]  tbl_addr = 4'd0;
    logic [15:0] tbl_data = 16'd0;
    logic [15:0] duty;

    always #2 clk = ~clk;

    pfc_duty_seq #(.N_ENTRIES(N), .DEB_CYCLES(DEB), .PWM_STEPS(1000), .FRAC_W(5)) u0 (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .sw_tick(sw_tick),
        .gain_k(gain_k), .gain_rip(gain_rip), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
        .tbl_addr(tbl_addr), .tbl_data(tbl_data), .duty(duty)
    );

    int    n_checks = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    int    ta [N];
    int    tb [N];
    int    tc [N];
    bit    m_synced = 1'b0;
    int    m_j = 0;
    int    m_run = 0;
    int    m_span = N;
    int    exp_d = 0;
    bit    hi_seen = 1'b0;
    bit    lo_seen = 1'b0;
    string cur_req = "R1";

    task automatic chk(input string req, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s duty actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int model_duty(input int i);
        longint k = longint'(gain_k);
        longint g = longint'(gain_rip);
        longint a = FULL - ((k * ta[i]) >>> 14);
        longint p = FULL - ((k * tb[i]) >>> 14);
        longint c = ((32768 - k) * tc[i]) >>> 14;
        longint t = a + ((((p - a) + c) * g) >>> 14);
        if (t < 0) t = 0;
        if (t > FULL - 1) t = FULL - 1;
        return int'(t);
    endfunction

    function automatic int model_idx();
        int v = (m_j * N) / m_span;
        return (v > N - 1) ? N - 1 : v;
    endfunction

    task automatic cyc(input bit t);
        sw_tick = t;
        @(posedge clk);
        if (t && m_synced) begin
            exp_d = model_duty(model_idx());
            m_j++;
            if (m_run < RMAX) m_run++;
        end
        @(negedge clk);
        sw_tick = 1'b0;
        chk(t ? cur_req : "R5", int'(duty), exp_d);
        if (duty == 16'd31999) hi_seen = 1'b1;
        if (duty == 16'd0 && m_synced && cur_req == "R9") lo_seen = 1'b1;
    endtask

    task automatic run_ticks(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            cyc(1'b1);
            cyc(1'b0);
            cyc(1'b0);
        end
    endtask

    task automatic zero_cross();
        cmp_raw = 1'b1;
        repeat (DEB + 6) cyc(1'b0);
        m_span   = m_synced ? ((m_run < N / 2) ? N / 2 : m_run) : N;
        m_synced = 1'b1;
        m_j      = 0;
        m_run    = 0;
        cmp_raw  = 1'b0;
        repeat (DEB + 6) cyc(1'b0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            ta[i] = (i == 0 || i == N - 1) ? 0 : 8000 + 1500 * i;
            tb[i] = ta[i] - 300 + 200 * (i % 4);
            tc[i] = 50 * (i % 5) - 100;
        end
        @(negedge clk);
        repeat (3) begin
            @(negedge clk);
            chk("R1", int'(duty), 0);
        end
        rst_n = 1'b1;

        // R2: load all three tables through the port
        for (int i = 0; i < N; i++) begin
            for (int s = 0; s < 3; s++) begin
                tbl_we   = 1'b1;
                tbl_sel  = 2'(s);
                tbl_addr = 4'(i);
                tbl_data = 16'(s == 0 ? ta[i] : (s == 1 ? tb[i] : tc[i]));
                cyc(1'b0);
            end
        end
        tbl_we = 1'b0;

        cur_req = "R1";
        run_ticks(4);

        zero_cross();
        cur_req = "R2";
        cyc(1'b1);
        chk("R4", int'(duty), model_duty(0));
        cyc(1'b0);
        run_ticks(15);

        zero_cross();
        gain_k  = 16'd18000;
        cur_req = "R6";
        run_ticks(16);

        zero_cross();
        gain_k   = 16'd15000;
        gain_rip = 16'd22000;
        cur_req  = "R7";
        run_ticks(5);
        cur_req  = "R3";
        cmp_raw  = 1'b1;
        repeat (3) cyc(1'b0);
        cmp_raw  = 1'b0;
        repeat (DEB + 4) cyc(1'b0);
        run_ticks(19);

        zero_cross();
        cur_req = "R8";
        run_ticks(10);

        zero_cross();
        run_ticks(10);

        zero_cross();
        gain_k   = 16'd32767;
        gain_rip = 16'd16384;
        cur_req  = "R9";
        run_ticks(12);

        zero_cross();
        gain_k  = 16'd16384;
        cur_req = "R8";
        run_ticks(5);
        zero_cross();
        run_ticks(8);

        chk("R9", int'(hi_seen), 1);
        chk("R9", int'(lo_seen), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule